// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two 32-bit timers that count down by one on every system clock while enabled. A small register bus reaches them: address, write data, write strobe, read strobe and read data. Channel 0 is meant to run freely with auto-reload as a time base. Software reads its count and inverts the bits to get elapsed ticks. Channel 1 is an event timer. It can re-arm itself on every expiry (periodic), or it can run once and stop (one-shot).

When a channel counts down to zero, it latches a bit in a shared cause register. A mask register selects which cause bits drive the single interrupt output, and that output is registered. Software acknowledges an event by writing zero to its cause bit. To arm a one-shot delay of V+1 clocks, software writes V to the channel's count register.

Top module: `dual_dn_timer`

## Requirements
- R1: After reset, the control, both reload registers, cause and mask read 0, both count registers read 0xFFFFFFFF, and `irq_o` is low.
- R2: The control word at 0x000 holds four bits: bit 0 enables channel 0, bit 1 enables reload on channel 0, bit 2 enables channel 1 and bit 3 enables reload on channel 1. Reads return these bits with all upper bits zero.
- R3: While a channel is enabled and its count is non-zero, the count drops by exactly one per clock.
- R4: With reload enabled and reload value N, a channel expires every N+1 clocks. The first expiry comes N+1 clocks after the channel is enabled with count N.
- R5: With reload disabled, a channel expires once when its count reaches zero, then holds at zero and does not expire again until its count register is written.
- R6: A write of V to a count register (0x014 for channel 0, 0x01C for channel 1) loads V directly, whatever the reload register (0x010 / 0x018) holds. The channel then expires V+1 clocks after the write edge.
- R7: An expiry of channel 0 sets cause bit 1 and an expiry of channel 1 sets cause bit 2 (cause at 0x110). If an expiry and a clearing write to the same bit happen in the same cycle, the bit stays set.
- R8: Writing the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R9: `irq_o` is the registered OR of (cause AND mask), with the mask at 0x114, bits 1 and 2. It therefore follows a cause or mask change one clock later.
- R10: Clearing a channel's enable bit freezes its count. Clearing a mask bit drops the interrupt but keeps the latched cause bit.
- R11: Read data appears on `rdata_o` the clock after `rd_i` is sampled. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both timers tick on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt: any unmasked cause bit set |

## Verification
The assertions assume that `wr_i` and `rd_i` are single-cycle strobes with a stable address. They also assume that a count write takes precedence over counting and expiry in the same cycle. The bench keeps to this by driving every access for exactly one clock edge from the falling edge, and it never writes a count register on the cycle it is watching for an expiry. The periodic sweep uses reload values of at least 2, plus a separate check for a reload value of 0. This keeps each acknowledge write off the next expiry edge, so the measured interval depends on the reload value alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned CAUSE_LSB = 1;
  localparam int unsigned OFF_CTRL  = 'h000;
  localparam int unsigned OFF_CAUSE = 'h110;
  localparam int unsigned OFF_MASK  = 'h114;

  function automatic int unsigned rld_off(input int unsigned ch);
    return 'h010 + 8 * ch;
  endfunction

  function automatic int unsigned cnt_off(input int unsigned ch);
    return 'h014 + 8 * ch;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rld_en_i,
  input  logic             cnt_we_i,
  input  logic             rld_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             spent_q;

  // one-shot that already fired stays silent until re-armed
  assign exp_o = en_i && (cnt_q == '0) && !spent_q && !cnt_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      spent_q <= 1'b0;
    end else if (cnt_we_i) begin
      cnt_q   <= wdata_i;
      spent_q <= 1'b0;
    end else begin
      if (exp_o) begin
        if (rld_en_i) cnt_q <= rld_q;
      end else if (en_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (rld_en_i)   spent_q <= 1'b0;
      else if (exp_o) spent_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_we_i) rld_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cnt_we_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r5_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spent_q && !cnt_we_i && !rld_en_i) |=> (cnt_q == '0) && !exp_o);

  a_r10_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] exp_i,
  input  logic            cause_we_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] cause_q, mask_q;
  logic            irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      // set beats clear in the same cycle
      cause_q <= (cause_we_i ? (cause_q & wdata_i) : cause_q) | exp_i;
      if (mask_we_i) mask_q <= wdata_i;
      irq_q <= |(cause_q & mask_q);
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    a_r7_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exp_i[k] |=> cause_q[k]);
    a_r8_cause_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_we_i && !wdata_i[k] && !exp_i[k]) |=> !cause_q[k]);
  end

  a_r9_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !irq_o);
endmodule

// File: rtl/dual_dn_timer.sv
module dual_dn_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = 2 * NCH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt   [NCH];
  logic [CNT_W-1:0]  rld   [NCH];
  logic [NCH-1:0]    exp_v, cause_v, mask_v;
  logic [CNT_W-1:0]  rd_val, rdata_q;

  wire sel_ctrl  = addr_i == ADDR_W'(OFF_CTRL);
  wire sel_cause = addr_i == ADDR_W'(OFF_CAUSE);
  wire sel_mask  = addr_i == ADDR_W'(OFF_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (wr_i && sel_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ctrl_q[2*ch]),
      .rld_en_i (ctrl_q[2*ch+1]),
      .cnt_we_i (wr_i && addr_i == ADDR_W'(cnt_off(ch))),
      .rld_we_i (wr_i && addr_i == ADDR_W'(rld_off(ch))),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt[ch]),
      .rld_o    (rld[ch]),
      .exp_o    (exp_v[ch])
    );
  end

  tmr_irq #(.NSRC(NCH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exp_i      (exp_v),
    .cause_we_i (wr_i && sel_cause),
    .mask_we_i  (wr_i && sel_mask),
    .wdata_i    (wdata_i[CAUSE_LSB +: NCH]),
    .cause_o    (cause_v),
    .mask_o     (mask_v),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (sel_ctrl)  rd_val[CTRL_W-1:0] = ctrl_q;
    if (sel_cause) rd_val[CAUSE_LSB +: NCH] = cause_v;
    if (sel_mask)  rd_val[CAUSE_LSB +: NCH] = mask_v;
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr_i == ADDR_W'(rld_off(ch))) rd_val = rld[ch];
      if (addr_i == ADDR_W'(cnt_off(ch))) rd_val = cnt[ch];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  a_r11_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_dual_dn_timer.sv
module sim_dual_dn_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  dual_dn_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_irq(inout int k);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); k++; @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int k;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd_reg(12'h000, d); chk("R1 ctrl", d, 0);
    rd_reg(12'h010, d); chk("R1 reload0", d, 0);
    rd_reg(12'h014, d); chk("R1 count0", d, 32'hFFFF_FFFF);
    rd_reg(12'h018, d); chk("R1 reload1", d, 0);
    rd_reg(12'h01C, d); chk("R1 count1", d, 32'hFFFF_FFFF);
    rd_reg(12'h110, d); chk("R1 cause", d, 0);
    rd_reg(12'h114, d); chk("R1 mask", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R11 unmapped reads zero
    wr_reg(12'h004, 32'hDEAD_BEEF);
    rd_reg(12'h004, d); chk("R11 unmapped", d, 0);

    // R2 control bits
    wr_reg(12'h000, 32'hFFFF_FFFA);
    rd_reg(12'h000, d); chk("R2 ctrl readback", d, 32'hA);
    wr_reg(12'h000, 32'h0);

    // R3 decrement, R10 freeze
    wr_reg(12'h014, 32'd1000);
    wr_reg(12'h000, 32'h1);
    rd_reg(12'h014, d); rd_reg(12'h014, d2);
    chk("R3 step", d - d2, 1);
    wr_reg(12'h000, 32'h0);
    rd_reg(12'h014, d); idle(5); rd_reg(12'h014, d2);
    chk("R10 frozen", d2, d);

    // R5/R6 one-shot sweep on channel 1
    wr_reg(12'h018, 32'd3);
    wr_reg(12'h114, 32'h4);
    wr_reg(12'h000, 32'h4);
    for (int v = 0; v < 10; v++) begin
      wr_reg(12'h110, 32'h0);
      wr_reg(12'h01C, v);
      k = 0; wait_irq(k);
      chk("R6 oneshot delay", k, v + 2);
      wr_reg(12'h110, 32'h0);
      idle(10);
      chk("R5 no refire", {31'd0, irq}, 0);
      rd_reg(12'h01C, d); chk("R5 holds zero", d, 0);
    end

    // R7/R8/R9/R10 cause and mask
    wr_reg(12'h114, 32'h0);
    wr_reg(12'h01C, 32'h0);
    wr_reg(12'h014, 32'h0);
    wr_reg(12'h000, 32'h5);
    wr_reg(12'h000, 32'h0);
    idle(3);
    rd_reg(12'h110, d); chk("R7 both causes", d, 32'h6);
    chk("R10 masked irq low", {31'd0, irq}, 0);
    wr_reg(12'h114, 32'h2);
    idle(1);
    chk("R9 irq after unmask", {31'd0, irq}, 1);
    wr_reg(12'h110, 32'h2);
    rd_reg(12'h110, d); chk("R8 write-1 keeps", d, 32'h2);
    wr_reg(12'h110, 32'h0);
    idle(1);
    chk("R9 irq after clear", {31'd0, irq}, 0);

    // R7 set beats clear: reload 0 expires every clock
    wr_reg(12'h010, 32'h0);
    wr_reg(12'h014, 32'h0);
    wr_reg(12'h000, 32'h3);
    idle(2);
    wr_reg(12'h110, 32'h0);
    rd_reg(12'h110, d); chk("R7 set wins", d, 32'h2);
    wr_reg(12'h000, 32'h0);

    // R4 periodic sweep on channel 0
    for (int n = 2; n < 8; n++) begin
      wr_reg(12'h000, 32'h0);
      wr_reg(12'h010, n);
      wr_reg(12'h014, n);
      wr_reg(12'h110, 32'h0);
      wr_reg(12'h000, 32'h3);
      k = 0; wait_irq(k);
      chk("R4 first expiry", k, n + 2);
      for (int p = 0; p < 3; p++) begin
        wr_reg(12'h110, 32'h0);
        k = 1; wait_irq(k);
        chk("R4 period", k, n + 1);
      end
    end
    wr_reg(12'h000, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule